// File: doc/BRIEF.md
# Two-Channel Successive-Approximation ADC Serial Master

This block drives one conversion frame on the serial link of a 12-bit, two-input successive-approximation converter each time a start pulse is accepted. It pulls chip select low, runs exactly sixteen serial clock periods, shifts a 16-bit control word out MSB first, and captures the converter's 16-bit reply. When the frame ends it hands back the low 12 bits of the reply with a single-cycle valid strobe.

A sample-rate timer outside this block issues the start pulses. An input picks the converter input for the frame, and that choice lands in one bit of the control word. The serial clock rate is set at build time by a divider parameter: each half period lasts `DIV` system clocks. While a frame runs, the block ignores further start pulses and raises a busy output.

Top module: `sar_spi_master`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 1, `adc_mosi` is 0, `busy` is 0 and `result_valid` is 0.
- R2: Each frame contains exactly 16 rising edges of `adc_sclk` while `adc_cs_n` is 0.
- R3: The control word goes out MSB first. `adc_mosi` changes during a frame only on rising `adc_sclk` edges. Bit 11 of the word equals `chan_sel` as sampled with the accepted start (1 selects the second input), and every other bit is 0.
- R4: Every `adc_sclk` half period inside a frame lasts `DIV` system clock cycles, so the serial period is 2*`DIV` cycles (8 with the default of 4).
- R5: `adc_miso` is sampled on each falling `adc_sclk` edge, MSB first, into a 16-bit word. `result` takes bits 11..0 of that word, and the upper four bits are discarded.
- R6: `result_valid` is high for exactly one system cycle per frame. That cycle is the one in which `adc_cs_n` returns to 1, `DIV` cycles after the 16th falling edge.
- R7: `busy` rises in the cycle after an accepted start and stays high until the cycle in which `adc_cs_n` returns to 1. It is always the inverse of `adc_cs_n`.
- R8: A start pulse that arrives while `busy` is 1 has no effect: the frame keeps its 16 clocks, its control word and its single result.
- R9: `adc_sclk` is 1 whenever `adc_cs_n` is 1. An accepted start drives both low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion frame (single-cycle pulse) |
| chan_sel | input | 1 | Converter input for the frame: 0 first, 1 second |
| adc_miso | input | 1 | Serial data returned by the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial control word to the converter |
| result | output | 12 | Latched conversion result |
| result_valid | output | 1 | Single-cycle strobe marking a new `result` |
| busy | output | 1 | Frame in progress |

## Verification
The bench plays the converter: it returns known 16-bit replies, including one whose top four bits are set, so a design that latched the wrong slice of the capture word would report corrupted results. It rebuilds the outgoing control word from `adc_mosi` at each falling edge, which exposes a swapped channel bit or data launched on the wrong edge. It also counts rising edges and measures their spacing, which exposes an off-by-one frame length or a divider that is one cycle short. A start pulse injected mid-frame with the opposite channel would show up as a second result, an extended frame or a changed control word if the design failed to ignore it.

// File: rtl/sar_spi_pkg.sv
package sar_spi_pkg;

    // Default link geometry
    localparam int unsigned DEF_FRAME_BITS  = 16;
    localparam int unsigned DEF_RESULT_BITS = 12;
    localparam int unsigned DEF_CHAN_POS    = 11;
    localparam int unsigned DEF_DIV         = 4;

    // Frame sequencer state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-tick event decoded by the sequencer for the shift unit
    typedef struct packed {
        logic launch;   // rising serial edge: put next control bit out
        logic capture;  // falling serial edge: take one reply bit in
        logic finish;   // end of frame: release chip select, publish result
    } seq_evt_t;

    localparam seq_evt_t EVT_NONE = '{launch: 1'b0, capture: 1'b0, finish: 1'b0};

    // Number of serial edges in a frame
    function automatic int unsigned edge_count(input int unsigned frame_bits);
        return 2 * frame_bits;
    endfunction

endpackage

// File: rtl/sar_spi_tick.sv
module sar_spi_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/sar_spi_seq.sv
module sar_spi_seq
    import sar_spi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     tick,
    output logic     cs_n,
    output logic     sclk,
    output logic     busy,
    output seq_evt_t evt
);
    localparam int unsigned EDGES = edge_count(FRAME_BITS);
    localparam int unsigned PW    = $clog2(EDGES + 1);
    localparam logic [PW-1:0] END_PH = PW'(EDGES);

    seq_state_e    state;
    logic [PW-1:0] ph;

    // Even phases are rising edges, odd phases falling, the last one ends the frame
    always_comb begin
        evt = EVT_NONE;
        if (state == SEQ_RUN && tick) begin
            if (ph == END_PH) begin
                evt.finish = 1'b1;
            end else if (ph[0]) begin
                evt.capture = 1'b1;
            end else begin
                evt.launch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cs_n  <= 1'b1;
            sclk  <= 1'b1;
            busy  <= 1'b0;
            ph    <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_RUN;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b0;
                        busy  <= 1'b1;
                        ph    <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (tick) begin
                        if (ph == END_PH) begin
                            state <= SEQ_IDLE;
                            cs_n  <= 1'b1;
                            sclk  <= 1'b1;
                            busy  <= 1'b0;
                            ph    <= '0;
                        end else begin
                            sclk <= ~ph[0];
                            ph   <= ph + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_spi_shift.sv
module sar_spi_shift
    import sar_spi_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned RESULT_BITS = 12,
    parameter int unsigned CHAN_POS    = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   chan,
    input  logic                   miso,
    input  seq_evt_t               evt,
    output logic                   mosi,
    output logic [RESULT_BITS-1:0] result,
    output logic                   valid
);
    logic [FRAME_BITS-1:0] ctrl_word;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;

    // Control word: only the channel position carries the channel choice
    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_ctrl
        if (i == CHAN_POS) begin : g_chan
            assign ctrl_word[i] = chan;
        end else begin : g_zero
            assign ctrl_word[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            rx_sr  <= '0;
            mosi   <= 1'b0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                tx_sr <= ctrl_word;
                rx_sr <= '0;
                mosi  <= 1'b0;
            end
            if (evt.launch) begin
                mosi  <= tx_sr[FRAME_BITS-1];
                tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            end
            if (evt.capture) begin
                rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
            end
            if (evt.finish) begin
                result <= rx_sr[RESULT_BITS-1:0];
                valid  <= 1'b1;
                mosi   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar_spi_master.sv
module sar_spi_master
    import sar_spi_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = DEF_FRAME_BITS,
    parameter int unsigned RESULT_BITS = DEF_RESULT_BITS,
    parameter int unsigned CHAN_POS    = DEF_CHAN_POS,
    parameter int unsigned DIV         = DEF_DIV
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   chan_sel,
    input  logic                   adc_miso,
    output logic                   adc_cs_n,
    output logic                   adc_sclk,
    output logic                   adc_mosi,
    output logic [RESULT_BITS-1:0] result,
    output logic                   result_valid,
    output logic                   busy
);
    logic     accept;
    logic     tick;
    seq_evt_t evt;

    assign accept = start && !busy;

    sar_spi_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    sar_spi_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .tick   (tick),
        .cs_n   (adc_cs_n),
        .sclk   (adc_sclk),
        .busy   (busy),
        .evt    (evt)
    );

    sar_spi_shift #(
        .FRAME_BITS  (FRAME_BITS),
        .RESULT_BITS (RESULT_BITS),
        .CHAN_POS    (CHAN_POS)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .chan   (chan_sel),
        .miso   (adc_miso),
        .evt    (evt),
        .mosi   (adc_mosi),
        .result (result),
        .valid  (result_valid)
    );

endmodule

// File: rtl/sar_spi_master_chk.sv
module sar_spi_master_chk #(
    parameter int unsigned DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_mosi,
    input logic result_valid,
    input logic busy
);
    logic [15:0] half_cnt;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_sclk != sclk_d) begin
                half_cnt <= '0;
            end else if (half_cnt != 16'hFFFF) begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // R9
    idle_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    // R9
    accept_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !adc_cs_n && !adc_sclk));

    // R7
    busy_cs_chk: assert property (@(posedge clk) disable iff (rst)
        busy != adc_cs_n);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R6
    valid_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $rose(adc_cs_n));

    // R3
    mosi_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && !$past(adc_cs_n) && !$rose(adc_sclk)) |-> $stable(adc_mosi));

    // R4
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && !$past(adc_cs_n) && !$stable(adc_sclk)) |-> (half_cnt == 16'(DIV - 1)));

endmodule

bind sar_spi_master sar_spi_master_chk #(.DIV(DIV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_mosi     (adc_mosi),
    .result_valid (result_valid),
    .busy         (busy)
);

// File: tb/tb_sar_spi_master.sv
module tb_sar_spi_master;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        chan_sel = 1'b0;
    logic        adc_miso = 1'b0;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_mosi;
    logic [11:0] result;
    logic        result_valid;
    logic        busy;

    always #2.5 clk = ~clk;

    sar_spi_master #(.DIV(DIV)) dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .chan_sel     (chan_sel),
        .adc_miso     (adc_miso),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .adc_mosi     (adc_mosi),
        .result       (result),
        .result_valid (result_valid),
        .busy         (busy)
    );

    typedef struct {
        logic        chan;
        logic [11:0] data;
    } exp_t;

    exp_t q[$];

    int tests = 0;
    int fails = 0;

    // Converter model and frame observation state
    logic [15:0] adc_word = 16'h0;
    logic [15:0] adc_sh   = 16'h0;
    logic [15:0] cap      = 16'h0;
    int          rises    = 0;
    int          vcount   = 0;
    int          cyc      = 0;
    int          last_rise = -1;
    int          min_sp   = 1000000;
    int          max_sp   = 0;
    logic        prev_cs  = 1'b1;
    logic        prev_sclk = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: samples away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!adc_cs_n && prev_cs) begin
            adc_sh   = adc_word;
            adc_miso = adc_sh[15];
        end
        if (!adc_cs_n && !prev_cs && prev_sclk && !adc_sclk) begin
            cap      = {cap[14:0], adc_mosi};
            adc_sh   = {adc_sh[14:0], 1'b0};
            adc_miso = adc_sh[15];
        end
        if (!adc_cs_n && adc_sclk && !prev_sclk) begin
            rises++;
            if (last_rise >= 0) begin
                if (cyc - last_rise < min_sp) min_sp = cyc - last_rise;
                if (cyc - last_rise > max_sp) max_sp = cyc - last_rise;
            end
            last_rise = cyc;
        end
        if (result_valid) begin
            vcount++;
            if (q.size() == 0) begin
                check(1'b0, "R6", "unexpected result", int'(result), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result == e.data, "R5", "result", int'(result), int'(e.data));
                check(cap == (16'(e.chan) << 11), "R3", "control word", int'(cap),
                      int'(16'(e.chan) << 11));
                check(rises == 16, "R2", "rising edges", rises, 16);
                check(min_sp == 2*DIV && max_sp == 2*DIV, "R4", "sclk period",
                      max_sp, 2*DIV);
                check(adc_cs_n && !busy, "R7", "busy/cs at valid",
                      int'({busy, adc_cs_n}), 1);
            end
        end
        prev_cs   = adc_cs_n;
        prev_sclk = adc_sclk;
    end

    // Driver: pushes the expected item and runs one frame
    task automatic run_frame(input logic ch, input logic [15:0] word, input bit inject);
        exp_t e;
        e.chan = ch;
        e.data = word[11:0];
        q.push_back(e);
        adc_word  = word;
        rises     = 0;
        vcount    = 0;
        cap       = 16'h0;
        last_rise = -1;
        min_sp    = 1000000;
        max_sp    = 0;
        @(negedge clk);
        start    = 1'b1;
        chan_sel = ch;
        @(negedge clk);
        start    = 1'b0;
        chan_sel = ~ch;
        check(busy && !adc_cs_n && !adc_sclk, "R7", "busy after start",
              int'({busy, adc_cs_n, adc_sclk}), 4);
        if (inject) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy, "R8", "busy after ignored start", int'(busy), 1);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(vcount == 1, inject ? "R8" : "R6", "valid pulses per frame", vcount, 1);
        check(adc_cs_n && adc_sclk && !busy, "R9", "idle lines",
              int'({adc_cs_n, adc_sclk, busy}), 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(adc_cs_n && adc_sclk && !adc_mosi && !busy && !result_valid, "R1",
              "reset state", int'({adc_cs_n, adc_sclk, adc_mosi, busy, result_valid}), 5'b11000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(adc_cs_n && adc_sclk && !busy, "R1", "idle after reset",
              int'({adc_cs_n, adc_sclk, busy}), 6);

        run_frame(1'b0, 16'h05A3, 1'b0);
        run_frame(1'b1, 16'h0A5C, 1'b0);
        run_frame(1'b0, 16'h0FFF, 1'b0);
        run_frame(1'b1, 16'h0000, 1'b0);
        run_frame(1'b0, 16'hF123, 1'b0);   // R5 upper bits dropped
        run_frame(1'b0, 16'h03C9, 1'b1);   // R8 start mid-frame with other channel
        run_frame(1'b1, 16'h0801, 1'b0);

        check(q.size() == 0, "R6", "pending results", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule